// File: doc/BRIEF.md
# Accumulator Adder and Logic Unit

This block holds the working accumulator of a small single-register processor and a one-bit extension that serves as its seventeenth bit. Each clock edge it either keeps both registers or applies one operation picked by decoded control strobes. Three strobes select the memory-operand operations AND, ADD and load, but only while the execute-phase strobe is high. A register-group strobe, combined with one bit of a 12-bit sub-operation field, selects clear, complement, rotate or increment. An I/O-group strobe, combined with bit 11 of the same field, copies an 8-bit character into the low byte.

The operand register value and the character register value arrive as plain data inputs. The block drives the accumulator, the extension bit and four status flags. A sequencer uses these flags to decide skips. Memory and bus handling lie outside the block. The control strobes must be one-hot in each cycle.

Top module: `acc_unit`

## Requirements
- R1: While rst_ni is low, acc_o and ext_o are 0.
- R2: With exec_phase_i high and op_sel_i = 3'b001, the next acc_o is acc_o AND opnd_i, and ext_o is unchanged.
- R3: With exec_phase_i high and op_sel_i = 3'b010, the next acc_o is the low 16 bits of acc_o + opnd_i, and ext_o takes the carry-out.
- R4: With exec_phase_i high and op_sel_i = 3'b100, the next acc_o equals opnd_i, and ext_o is unchanged.
- R5: With reg_grp_i high, sub_op_i bit 11 clears acc_o and sub_op_i bit 10 clears ext_o. Each leaves the other register unchanged.
- R6: With reg_grp_i high, sub_op_i bit 9 inverts every bit of acc_o and sub_op_i bit 8 inverts ext_o. Each leaves the other register unchanged.
- R7: With reg_grp_i high, sub_op_i bit 7 rotates {acc_o, ext_o} right: the old ext_o goes to acc_o bit 15, and the old acc_o bit 0 goes to ext_o.
- R8: With reg_grp_i high, sub_op_i bit 6 rotates left: the old ext_o goes to acc_o bit 0, and the old acc_o bit 15 goes to ext_o.
- R9: With reg_grp_i high, sub_op_i bit 5 adds one to acc_o, wrapping 16'hFFFF to 0. ext_o is unchanged.
- R10: With io_grp_i high and sub_op_i bit 11 set, acc_o bits 7..0 take char_i. Bits 15..8 and ext_o are unchanged.
- R11: acc_pos_o is high when acc_o bit 15 is 0, and acc_neg_o is high when it is 1. acc_zero_o is high when acc_o is 0. ext_zero_o is high when ext_o is 0.
- R12: When no strobe is active, acc_o and ext_o hold their values. This includes the case where op_sel_i is set while exec_phase_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exec_phase_i | input | 1 | Execute-phase strobe for the memory-operand operations |
| op_sel_i | input | 3 | One-hot select: bit 0 AND, bit 1 ADD, bit 2 load |
| reg_grp_i | input | 1 | Register-group strobe |
| io_grp_i | input | 1 | I/O-group strobe |
| sub_op_i | input | 12 | Sub-operation bits for the register and I/O groups |
| opnd_i | input | 16 | Memory operand |
| char_i | input | 8 | Input character |
| acc_o | output | 16 | Accumulator |
| ext_o | output | 1 | Extension bit |
| acc_pos_o | output | 1 | Accumulator sign bit is clear |
| acc_neg_o | output | 1 | Accumulator sign bit is set |
| acc_zero_o | output | 1 | Accumulator is zero |
| ext_zero_o | output | 1 | Extension bit is zero |

## Verification
The bench builds the block with the default widths: a 16-bit accumulator and an 8-bit character. At these widths the bench can drive the carry-out into the extension bit, the wrap from 16'hFFFF to zero, and the sign bit at position 15 with hand-picked operands. The 8-bit character leaves a distinct upper byte, so the bench can show that the character transfer leaves it alone. Random operands extend the AND, ADD and rotate checks beyond the directed corner values.

// File: rtl/acc_unit_pkg.sv
package acc_unit_pkg;
  localparam int SUB_W = 12;
  // sub-operation bit positions (decoded by the sequencer, order is fixed)
  localparam int B_CLR_A = 11;
  localparam int B_CLR_E = 10;
  localparam int B_CMP_A = 9;
  localparam int B_CMP_E = 8;
  localparam int B_ROR   = 7;
  localparam int B_ROL   = 6;
  localparam int B_INC   = 5;
  localparam int B_CHAR  = 11;

  typedef enum logic [3:0] {
    OP_HOLD, OP_AND, OP_ADD, OP_LOAD, OP_CLR_A, OP_CLR_E, OP_CMP_A,
    OP_CMP_E, OP_ROR, OP_ROL, OP_INC, OP_CHAR
  } acc_op_e;
endpackage

// File: rtl/acc_op_dec.sv
module acc_op_dec
  import acc_unit_pkg::*;
(
  input  logic             exec_phase_i,
  input  logic [2:0]       op_sel_i,
  input  logic             reg_grp_i,
  input  logic             io_grp_i,
  input  logic [SUB_W-1:0] sub_op_i,
  output acc_op_e          op_o
);
  always_comb begin
    op_o = OP_HOLD;
    if (exec_phase_i && op_sel_i[0])      op_o = OP_AND;
    else if (exec_phase_i && op_sel_i[1]) op_o = OP_ADD;
    else if (exec_phase_i && op_sel_i[2]) op_o = OP_LOAD;
    else if (reg_grp_i) begin
      if (sub_op_i[B_CLR_A])      op_o = OP_CLR_A;
      else if (sub_op_i[B_CLR_E]) op_o = OP_CLR_E;
      else if (sub_op_i[B_CMP_A]) op_o = OP_CMP_A;
      else if (sub_op_i[B_CMP_E]) op_o = OP_CMP_E;
      else if (sub_op_i[B_ROR])   op_o = OP_ROR;
      else if (sub_op_i[B_ROL])   op_o = OP_ROL;
      else if (sub_op_i[B_INC])   op_o = OP_INC;
    end else if (io_grp_i && sub_op_i[B_CHAR]) begin
      op_o = OP_CHAR;
    end
  end
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_unit_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CHAR_W = 8
) (
  input  acc_op_e           op_i,
  input  logic [DATA_W-1:0] acc_q_i,
  input  logic              ext_q_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [CHAR_W-1:0] char_i,
  output logic [DATA_W-1:0] acc_d_o,
  output logic              ext_d_o
);
  localparam int SUM_W = DATA_W + 1;
  localparam int HI_W  = DATA_W - CHAR_W;

  logic [SUM_W-1:0]  sum;
  logic [DATA_W-1:0] inc;
  logic [DATA_W-1:0] with_char;

  assign sum = {1'b0, acc_q_i} + {1'b0, opnd_i};
  assign inc = acc_q_i + DATA_W'(1);

  generate
    if (HI_W > 0) begin : g_keep_hi
      assign with_char = {acc_q_i[DATA_W-1:CHAR_W], char_i};
    end else begin : g_full
      assign with_char = char_i[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    acc_d_o = acc_q_i;
    ext_d_o = ext_q_i;
    unique case (op_i)
      OP_AND:   acc_d_o = acc_q_i & opnd_i;
      OP_ADD:   {ext_d_o, acc_d_o} = sum;
      OP_LOAD:  acc_d_o = opnd_i;
      OP_CLR_A: acc_d_o = '0;
      OP_CLR_E: ext_d_o = 1'b0;
      OP_CMP_A: acc_d_o = ~acc_q_i;
      OP_CMP_E: ext_d_o = ~ext_q_i;
      OP_ROR:   {acc_d_o, ext_d_o} = {ext_q_i, acc_q_i};
      OP_ROL:   {ext_d_o, acc_d_o} = {acc_q_i, ext_q_i};
      OP_INC:   acc_d_o = inc;
      OP_CHAR:  acc_d_o = with_char;
      default:  ;
    endcase
  end
endmodule

// File: rtl/acc_status.sv
module acc_status #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] acc_i,
  input  logic              ext_i,
  output logic              pos_o,
  output logic              neg_o,
  output logic              zero_o,
  output logic              ext_zero_o
);
  assign neg_o      = acc_i[DATA_W-1];
  assign pos_o      = ~acc_i[DATA_W-1];
  assign zero_o     = ~|acc_i;
  assign ext_zero_o = ~ext_i;
endmodule

// File: rtl/acc_unit.sv
module acc_unit
  import acc_unit_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CHAR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exec_phase_i,
  input  logic [2:0]        op_sel_i,
  input  logic              reg_grp_i,
  input  logic              io_grp_i,
  input  logic [SUB_W-1:0]  sub_op_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [CHAR_W-1:0] char_i,
  output logic [DATA_W-1:0] acc_o,
  output logic              ext_o,
  output logic              acc_pos_o,
  output logic              acc_neg_o,
  output logic              acc_zero_o,
  output logic              ext_zero_o
);
  acc_op_e           op;
  logic [DATA_W-1:0] acc_q, acc_d;
  logic              ext_q, ext_d;

  acc_op_dec i_dec (
    .exec_phase_i (exec_phase_i),
    .op_sel_i     (op_sel_i),
    .reg_grp_i    (reg_grp_i),
    .io_grp_i     (io_grp_i),
    .sub_op_i     (sub_op_i),
    .op_o         (op)
  );

  acc_datapath #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) i_dp (
    .op_i    (op),
    .acc_q_i (acc_q),
    .ext_q_i (ext_q),
    .opnd_i  (opnd_i),
    .char_i  (char_i),
    .acc_d_o (acc_d),
    .ext_d_o (ext_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      ext_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      ext_q <= ext_d;
    end
  end

  acc_status #(.DATA_W(DATA_W)) i_stat (
    .acc_i      (acc_q),
    .ext_i      (ext_q),
    .pos_o      (acc_pos_o),
    .neg_o      (acc_neg_o),
    .zero_o     (acc_zero_o),
    .ext_zero_o (ext_zero_o)
  );

  assign acc_o = acc_q;
  assign ext_o = ext_q;
endmodule

// File: rtl/acc_unit_chk.sv
module acc_unit_chk
  import acc_unit_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CHAR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              exec_phase_i,
  input logic [2:0]        op_sel_i,
  input logic              reg_grp_i,
  input logic              io_grp_i,
  input logic [SUB_W-1:0]  sub_op_i,
  input logic [DATA_W-1:0] opnd_i,
  input logic [CHAR_W-1:0] char_i,
  input logic [DATA_W-1:0] acc_o,
  input logic              ext_o,
  input logic              acc_pos_o,
  input logic              acc_neg_o,
  input logic              acc_zero_o,
  input logic              ext_zero_o
);
  logic mem_grp;
  assign mem_grp = exec_phase_i && (|op_sel_i);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_r1: assert (acc_o == '0 && ext_o == 1'b0);
    end
  end

  p_ctl_onehot_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_grp, reg_grp_i, io_grp_i}));

  p_and_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_phase_i && op_sel_i == 3'b001 && !reg_grp_i && !io_grp_i)
    |=> (acc_o == $past(acc_o & opnd_i)) && (ext_o == $past(ext_o)));

  p_add_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_phase_i && op_sel_i == 3'b010 && !reg_grp_i && !io_grp_i)
    |=> ({ext_o, acc_o} == $past({1'b0, acc_o} + {1'b0, opnd_i})));

  p_ror_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_grp_i && sub_op_i == SUB_W'(1 << B_ROR) && !mem_grp && !io_grp_i)
    |=> ({acc_o, ext_o} == $past({ext_o, acc_o})));

  p_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!exec_phase_i && !reg_grp_i && !io_grp_i)
    |=> ($stable(acc_o) && $stable(ext_o)));

  p_flags_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_zero_o == (acc_o == '0)) && (acc_pos_o != acc_neg_o)
    && (acc_neg_o == acc_o[DATA_W-1]) && (ext_zero_o != ext_o));
endmodule

bind acc_unit acc_unit_chk #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) i_acc_unit_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .exec_phase_i(exec_phase_i),
  .op_sel_i(op_sel_i), .reg_grp_i(reg_grp_i), .io_grp_i(io_grp_i),
  .sub_op_i(sub_op_i), .opnd_i(opnd_i), .char_i(char_i), .acc_o(acc_o),
  .ext_o(ext_o), .acc_pos_o(acc_pos_o), .acc_neg_o(acc_neg_o),
  .acc_zero_o(acc_zero_o), .ext_zero_o(ext_zero_o)
);

// File: tb/test_acc_unit.sv
module test_acc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec_phase = 1'b0;
  logic [2:0]  op_sel = '0;
  logic        reg_grp = 1'b0;
  logic        io_grp = 1'b0;
  logic [11:0] sub_op = '0;
  logic [15:0] opnd = '0;
  logic [7:0]  chr = '0;
  logic [15:0] acc;
  logic        ext, pos, neg, zero, ezero;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  acc_unit i_acc_unit (
    .clk_i(clk), .rst_ni(rst_n), .exec_phase_i(exec_phase), .op_sel_i(op_sel),
    .reg_grp_i(reg_grp), .io_grp_i(io_grp), .sub_op_i(sub_op), .opnd_i(opnd),
    .char_i(chr), .acc_o(acc), .ext_o(ext), .acc_pos_o(pos), .acc_neg_o(neg),
    .acc_zero_o(zero), .ext_zero_o(ezero)
  );

  task automatic chk(input string tag, input logic [15:0] a_exp, input logic e_exp);
    checks++;
    if (acc !== a_exp || ext !== e_exp) begin
      errors++;
      $display("FAIL %s acc=%h ext=%b expected acc=%h ext=%b", tag, acc, ext, a_exp, e_exp);
    end
  endtask

  task automatic pulse(input logic [2:0] sel, input logic ex, input logic rg,
                       input logic io, input logic [11:0] sub,
                       input logic [15:0] d, input logic [7:0] c);
    @(negedge clk);
    op_sel = sel; exec_phase = ex; reg_grp = rg; io_grp = io;
    sub_op = sub; opnd = d; chr = c;
    @(negedge clk);
    op_sel = '0; exec_phase = 1'b0; reg_grp = 1'b0; io_grp = 1'b0;
    sub_op = '0; opnd = '0; chr = '0;
  endtask

  task automatic reg_op(input int bitpos);
    pulse(3'b000, 1'b0, 1'b1, 1'b0, 12'(1 << bitpos), 16'h0, 8'h0);
  endtask

  task automatic set_state(input logic [15:0] a, input logic e);
    pulse(3'b100, 1'b1, 1'b0, 1'b0, 12'h0, a, 8'h0);
    reg_op(10);
    if (e) reg_op(8);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 reset", 16'h0, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic t_and();
    for (int i = 0; i < 8; i++) begin
      logic [15:0] a = 16'($urandom), b = 16'($urandom);
      logic e = 1'($urandom);
      set_state(a, e);
      pulse(3'b001, 1'b1, 1'b0, 1'b0, 12'h0, b, 8'h0);
      chk("R2 and", a & b, e);
    end
  endtask

  task automatic t_add();
    set_state(16'hFFFF, 1'b0);
    pulse(3'b010, 1'b1, 1'b0, 1'b0, 12'h0, 16'h0001, 8'h0);
    chk("R3 add carry", 16'h0000, 1'b1);
    set_state(16'h1234, 1'b1);
    pulse(3'b010, 1'b1, 1'b0, 1'b0, 12'h0, 16'h0101, 8'h0);
    chk("R3 add no carry", 16'h1335, 1'b0);
    for (int i = 0; i < 8; i++) begin
      logic [15:0] a = 16'($urandom), b = 16'($urandom);
      logic [16:0] s = {1'b0, a} + {1'b0, b};
      set_state(a, 1'($urandom));
      pulse(3'b010, 1'b1, 1'b0, 1'b0, 12'h0, b, 8'h0);
      chk("R3 add random", s[15:0], s[16]);
    end
  endtask

  task automatic t_load();
    set_state(16'h0F0F, 1'b1);
    pulse(3'b100, 1'b1, 1'b0, 1'b0, 12'h0, 16'hBEEF, 8'h0);
    chk("R4 load", 16'hBEEF, 1'b1);
  endtask

  task automatic t_clear();
    set_state(16'hA5A5, 1'b1);
    reg_op(11);
    chk("R5 clear acc", 16'h0000, 1'b1);
    set_state(16'hA5A5, 1'b1);
    reg_op(10);
    chk("R5 clear ext", 16'hA5A5, 1'b0);
  endtask

  task automatic t_complement();
    set_state(16'h00FF, 1'b0);
    reg_op(9);
    chk("R6 invert acc", 16'hFF00, 1'b0);
    reg_op(8);
    chk("R6 invert ext", 16'hFF00, 1'b1);
  endtask

  task automatic t_ror();
    set_state(16'h0001, 1'b0);
    reg_op(7);
    chk("R7 ror bit0 to ext", 16'h0000, 1'b1);
    reg_op(7);
    chk("R7 ror ext to bit15", 16'h8000, 1'b0);
    for (int i = 0; i < 4; i++) begin
      logic [15:0] a = 16'($urandom);
      logic e = 1'($urandom);
      set_state(a, e);
      reg_op(7);
      chk("R7 ror random", {e, a[15:1]}, a[0]);
    end
  endtask

  task automatic t_rol();
    set_state(16'h8000, 1'b0);
    reg_op(6);
    chk("R8 rol bit15 to ext", 16'h0000, 1'b1);
    reg_op(6);
    chk("R8 rol ext to bit0", 16'h0001, 1'b0);
    for (int i = 0; i < 4; i++) begin
      logic [15:0] a = 16'($urandom);
      logic e = 1'($urandom);
      set_state(a, e);
      reg_op(6);
      chk("R8 rol random", {a[14:0], e}, a[15]);
    end
  endtask

  task automatic t_inc();
    set_state(16'hFFFF, 1'b0);
    reg_op(5);
    chk("R9 inc wrap", 16'h0000, 1'b0);
    set_state(16'h7FFF, 1'b1);
    reg_op(5);
    chk("R9 inc", 16'h8000, 1'b1);
  endtask

  task automatic t_char();
    set_state(16'hC3A5, 1'b1);
    pulse(3'b000, 1'b0, 1'b0, 1'b1, 12'h800, 16'hFFFF, 8'h5A);
    chk("R10 char low byte", 16'hC35A, 1'b1);
    pulse(3'b000, 1'b0, 1'b0, 1'b1, 12'h400, 16'hFFFF, 8'h11);
    chk("R10 other io bit ignored", 16'hC35A, 1'b1);
  endtask

  task automatic t_flags();
    set_state(16'h0000, 1'b0);
    checks++;
    if ({pos, neg, zero, ezero} !== 4'b1011) begin
      errors++;
      $display("FAIL R11 flags zero got %b expected 1011", {pos, neg, zero, ezero});
    end
    set_state(16'h8001, 1'b1);
    checks++;
    if ({pos, neg, zero, ezero} !== 4'b0100) begin
      errors++;
      $display("FAIL R11 flags negative got %b expected 0100", {pos, neg, zero, ezero});
    end
  endtask

  task automatic t_hold();
    set_state(16'h2468, 1'b1);
    pulse(3'b111, 1'b0, 1'b0, 1'b0, 12'hFFF, 16'h0000, 8'hFF);
    chk("R12 select without exec", 16'h2468, 1'b1);
    repeat (3) @(negedge clk);
    chk("R12 idle hold", 16'h2468, 1'b1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    t_reset();
    t_and();
    t_add();
    t_load();
    t_clear();
    t_complement();
    t_ror();
    t_rol();
    t_inc();
    t_char();
    t_flags();
    t_hold();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule